// File: doc/BRIEF.md
# Residual Energy Window Timer

This block measures how long a supply keeps its DC outputs in regulation after it has announced a power failure. It watches a power-good line and a set of rails, each delivered as a parallel converter word on a common sample strobe. Every rail has a programmable nominal level. The block times from the strobe on which power-good is first seen low to the beginning of the first sustained sag on any rail. It reports that interval in strobe ticks, together with the rail that sagged.

Software arms the block once. After that it works without supervision: it waits for power-good to fall, counts ticks, and keeps a run-length count for each rail. A sag counts only when a rail stays under roughly 95 % of its nominal level for a full run of consecutive samples, so single noisy samples are ignored. At the default 100 kHz strobe, one tick is 10 µs and a run is 25 samples (250 µs). The default 16-bit counter covers the expected 10 ms to 400 ms range.

Top module: `rew_timer`

## Requirements
- R1: After reset, all outputs are zero, and the block ignores strobes, power-good edges and rail samples until the arm input is pulsed.
- R2: A rail sample is below threshold only when it is strictly less than floor(nominal × 243 / 256). A sample equal to that value is not below threshold.
- R3: A rail sag is declared on the strobe that carries its 25th consecutive below-threshold sample (RUN_LEN). Any sample at or above the threshold restarts that rail's run from zero.
- R4: Timing starts on the first strobe that samples power-good low after a strobe that sampled it high. That strobe is tick 0, and each later strobe is one more tick. Inputs are ignored in cycles without a strobe.
- R5: On a declared sag, windowTicks holds the tick of the first sample of the qualifying run, and windowValid goes high one clock after the declaring strobe.
- R6: sagRail gives the index of the rail that sagged first. When several rails qualify on the same strobe, the lowest index is reported.
- R7: If power-good is sampled high on a strobe before any sag is declared, the measurement is abandoned and windowValid and windowOverflow stay low until the next arm. When a sag is declared on the same strobe that sees power-good high, the sag is reported.
- R8: If the strobe at tick 2^CNT_W−1 declares no sag, windowOverflow is set, windowTicks saturates at 2^CNT_W−1, and windowValid stays low.
- R9: A pulse on arm, in any state, clears windowTicks, sagRail, windowValid and windowOverflow on the next clock and starts a fresh wait for a power-good fall.
- R10: If power-good is already low when the block is armed, no measurement starts until power-good has been sampled high and then low.
- R11: Once windowValid is set, the result stays unchanged through later strobes until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Clear results and arm a new measurement |
| sampleStb | input | 1 | One-cycle sample strobe at the tick rate |
| pwrGood | input | 1 | Supply power-good level |
| railLevel | input | NUM_RAILS×SAMPLE_W | Packed rail samples, rail 0 in the low bits |
| railNominal | input | NUM_RAILS×SAMPLE_W | Packed programmable nominal level per rail |
| windowTicks | output | CNT_W | Measured window in ticks |
| windowValid | output | 1 | A sag was found and windowTicks is valid |
| windowOverflow | output | 1 | Tick counter saturated with no sag |
| sagRail | output | max(1,clog2(NUM_RAILS)) | Rail that sagged first |

## Verification
The bench sweeps sag start points and ties across three rails and uses strobes with idle gaps in which the rail words are garbage. A design that counted the garbage cycles, or that timed the window to the end of the run instead of its start, would report windows that are off by a fixed amount. The bench also targets a sample exactly at threshold, a glitch on the last sample of a run, power-good recovering one tick before the declaring strobe and on the declaring strobe itself, a sag that qualifies exactly on the saturating tick, and arming while power-good is already low. For each of these, a wrong design would either produce a spurious result, lose a valid one, or misreport the overflow flag.

// File: rtl/rew_pkg.sv
package rew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_TIMING,
    ST_HALT
  } rewState_e;

  typedef struct packed {
    logic clearAll;
    logic advance;
    logic capture;
    logic setOvf;
  } rewCtrl_t;
endpackage

// File: rtl/rew_rail_lane.sv
module rew_rail_lane #(
  parameter int SAMPLE_W  = 12,
  parameter int RUN_LEN   = 25,
  parameter int THR_NUM   = 243,
  parameter int THR_SHIFT = 8,
  parameter int RUN_W     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearAll,
  input  logic                advance,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [SAMPLE_W-1:0] nominal,
  output logic                dropNow
);
  localparam int PROD_W = SAMPLE_W + $clog2(THR_NUM + 1);

  logic [PROD_W-1:0] scaled;
  logic [PROD_W-1:0] thrLevel;
  logic              below;
  logic [RUN_W-1:0]  runCnt;

  assign scaled   = PROD_W'(nominal) * PROD_W'(THR_NUM);
  assign thrLevel = scaled >> THR_SHIFT;
  assign below    = PROD_W'(level) < thrLevel;
  assign dropNow  = below && (runCnt == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (clearAll) begin
      runCnt <= '0;
    end else if (advance) begin
      if (!below) begin
        runCnt <= '0;
      end else if (runCnt != RUN_W'(RUN_LEN)) begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rew_ctrl.sv
module rew_ctrl
  import rew_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     arm,
  input  logic     sampleStb,
  input  logic     pwrGood,
  input  logic     dropAny,
  input  logic     tickAtMax,
  output rewCtrl_t ctl
);
  rewState_e state, stateNxt;
  logic      pgPrev, pgPrevNxt;

  always_comb begin
    stateNxt  = state;
    pgPrevNxt = pgPrev;
    ctl       = '0;
    if (arm) begin
      ctl.clearAll = 1'b1;
      stateNxt     = ST_ARMED;
      pgPrevNxt    = 1'b0;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (sampleStb) begin
            pgPrevNxt = pwrGood;
            if (pgPrev && !pwrGood) begin
              ctl.advance = 1'b1;
              stateNxt    = ST_TIMING;
            end
          end
        end
        ST_TIMING: begin
          if (sampleStb) begin
            if (dropAny) begin
              ctl.advance = 1'b1;
              ctl.capture = 1'b1;
              stateNxt    = ST_HALT;
            end else if (pwrGood) begin
              stateNxt = ST_IDLE;
            end else if (tickAtMax) begin
              ctl.setOvf = 1'b1;
              stateNxt   = ST_HALT;
            end else begin
              ctl.advance = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pgPrev <= 1'b0;
    end else begin
      state  <= stateNxt;
      pgPrev <= pgPrevNxt;
    end
  end

  AST_CAPTURE_IN_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> (state == ST_TIMING) && sampleStb); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capture, ctl.setOvf})); // R8
endmodule

// File: rtl/rew_datapath.sv
module rew_datapath
  import rew_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int SAMPLE_W  = 12,
  parameter int CNT_W     = 16,
  parameter int RUN_LEN   = 25,
  parameter int THR_NUM   = 243,
  parameter int THR_SHIFT = 8,
  parameter int IDX_W     = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rewCtrl_t                      ctl,
  input  logic [NUM_RAILS*SAMPLE_W-1:0] railLevel,
  input  logic [NUM_RAILS*SAMPLE_W-1:0] railNominal,
  output logic                          dropAny,
  output logic                          tickAtMax,
  output logic [CNT_W-1:0]              windowTicks,
  output logic                          windowValid,
  output logic                          windowOverflow,
  output logic [IDX_W-1:0]              sagRail
);
  localparam int              RUN_W    = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] TICK_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RUN_BACK = CNT_W'(RUN_LEN - 1);

  logic [NUM_RAILS-1:0] dropVec;
  logic [IDX_W-1:0]     firstIdx;
  logic [CNT_W-1:0]     tickCnt;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_lane
    rew_rail_lane #(
      .SAMPLE_W (SAMPLE_W),
      .RUN_LEN  (RUN_LEN),
      .THR_NUM  (THR_NUM),
      .THR_SHIFT(THR_SHIFT),
      .RUN_W    (RUN_W)
    ) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .clearAll(ctl.clearAll),
      .advance (ctl.advance),
      .level   (railLevel[r*SAMPLE_W +: SAMPLE_W]),
      .nominal (railNominal[r*SAMPLE_W +: SAMPLE_W]),
      .dropNow (dropVec[r])
    );
  end

  always_comb begin
    firstIdx = '0;
    for (int i = NUM_RAILS - 1; i >= 0; i--) begin
      if (dropVec[i]) firstIdx = IDX_W'(i);
    end
  end

  assign dropAny   = |dropVec;
  assign tickAtMax = (tickCnt == TICK_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (ctl.clearAll) begin
      tickCnt <= '0;
    end else if (ctl.advance && !tickAtMax) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      windowTicks    <= '0;
      windowValid    <= 1'b0;
      windowOverflow <= 1'b0;
      sagRail        <= '0;
    end else if (ctl.clearAll) begin
      windowTicks    <= '0;
      windowValid    <= 1'b0;
      windowOverflow <= 1'b0;
      sagRail        <= '0;
    end else if (ctl.capture) begin
      windowTicks <= tickCnt - RUN_BACK;
      windowValid <= 1'b1;
      sagRail     <= firstIdx;
    end else if (ctl.setOvf) begin
      windowTicks    <= TICK_MAX;
      windowOverflow <= 1'b1;
    end
  end

  AST_VALID_OVF_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(windowValid && windowOverflow)); // R8
  AST_WINDOW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    windowValid |-> windowTicks <= TICK_MAX - RUN_BACK); // R5
  AST_RAIL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    windowValid |-> int'(sagRail) < NUM_RAILS); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    windowValid && !ctl.clearAll |=> windowValid && $stable(windowTicks) && $stable(sagRail)); // R11
endmodule

// File: rtl/rew_timer.sv
module rew_timer
  import rew_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int SAMPLE_W  = 12,
  parameter int CNT_W     = 16,
  parameter int RUN_LEN   = 25,
  parameter int THR_NUM   = 243,
  parameter int THR_SHIFT = 8,
  localparam int IDX_W    = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          arm,
  input  logic                          sampleStb,
  input  logic                          pwrGood,
  input  logic [NUM_RAILS*SAMPLE_W-1:0] railLevel,
  input  logic [NUM_RAILS*SAMPLE_W-1:0] railNominal,
  output logic [CNT_W-1:0]              windowTicks,
  output logic                          windowValid,
  output logic                          windowOverflow,
  output logic [IDX_W-1:0]              sagRail
);
  rewCtrl_t ctl;
  logic     dropAny;
  logic     tickAtMax;

  rew_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .arm      (arm),
    .sampleStb(sampleStb),
    .pwrGood  (pwrGood),
    .dropAny  (dropAny),
    .tickAtMax(tickAtMax),
    .ctl      (ctl)
  );

  rew_datapath #(
    .NUM_RAILS(NUM_RAILS),
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W),
    .RUN_LEN  (RUN_LEN),
    .THR_NUM  (THR_NUM),
    .THR_SHIFT(THR_SHIFT),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .railLevel     (railLevel),
    .railNominal   (railNominal),
    .dropAny       (dropAny),
    .tickAtMax     (tickAtMax),
    .windowTicks   (windowTicks),
    .windowValid   (windowValid),
    .windowOverflow(windowOverflow),
    .sagRail       (sagRail)
  );

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> !windowValid && !windowOverflow && (windowTicks == '0)); // R9
endmodule

// File: tb/rew_timer_test.sv
module rew_timer_test;
  localparam int NR   = 3;
  localparam int SW   = 12;
  localparam int CW   = 10;
  localparam int RL   = 25;
  localparam int MAXT = (1 << CW) - 1;
  localparam int NONE = 1000000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          arm = 1'b0;
  logic          sampleStb = 1'b0;
  logic          pwrGood = 1'b1;
  logic [NR*SW-1:0] railLevel = '0;
  logic [NR*SW-1:0] railNominal = '0;
  logic [CW-1:0] windowTicks;
  logic          windowValid;
  logic          windowOverflow;
  logic [1:0]    sagRail;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  int nom[NR];
  int lowLvl[NR];
  int sagAt[NR];
  int glitchAt[NR];
  int abortAt;
  int gap;

  always #2 clk = ~clk;

  rew_timer #(.NUM_RAILS(NR), .SAMPLE_W(SW), .CNT_W(CW), .RUN_LEN(RL)) uut (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleStb(sampleStb), .pwrGood(pwrGood),
    .railLevel(railLevel), .railNominal(railNominal), .windowTicks(windowTicks),
    .windowValid(windowValid), .windowOverflow(windowOverflow), .sagRail(sagRail)
  );

  function automatic int thrOf(int n);
    return (n * 243) >> 8;
  endfunction

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setNominals();
    for (int r = 0; r < NR; r++) railNominal[r*SW +: SW] = SW'(nom[r]);
  endtask

  task automatic strobeIdle(bit pg, int count);
    for (int i = 0; i < count; i++) begin
      for (int r = 0; r < NR; r++) railLevel[r*SW +: SW] = SW'(nom[r]);
      pwrGood = pg;
      sampleStb = 1'b1;
      @(negedge clk);
      sampleStb = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic driveTick(int k);
    for (int r = 0; r < NR; r++)
      railLevel[r*SW +: SW] = SW'((k >= sagAt[r] && k != glitchAt[r]) ? lowLvl[r] : nom[r]);
    pwrGood = (k >= abortAt);
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    for (int g = 1; g < gap; g++) begin
      railLevel = '0;
      pwrGood = ~pwrGood;
      @(negedge clk);
    end
  endtask

  task automatic pulseArm(bit pg);
    pwrGood = pg;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic runCase(string tag, bit doArm);
    int best;
    int bidx;
    int st;
    int last;
    bit expValid;
    bit expOvf;
    best = NONE;
    bidx = 0;
    for (int r = 0; r < NR; r++) begin
      if (sagAt[r] != NONE && lowLvl[r] < thrOf(nom[r])) begin
        st = sagAt[r];
        if (glitchAt[r] >= st && glitchAt[r] < st + RL) st = glitchAt[r] + 1;
        if (st + RL - 1 < best) begin
          best = st + RL - 1;
          bidx = r;
        end
      end
    end
    expValid = (best <= MAXT) && (abortAt >= best);
    expOvf = !expValid && (abortAt > MAXT);
    last = expValid ? best : ((abortAt <= MAXT) ? abortAt : MAXT);
    setNominals();
    if (doArm) pulseArm(1'b1);
    strobeIdle(1'b1, 2);
    for (int k = 0; k <= last + 4; k++) driveTick(k);
    repeat (3) @(negedge clk);
    chk({tag, " R7 valid"}, int'(windowValid), int'(expValid));
    chk({tag, " R8 overflow"}, int'(windowOverflow), int'(expOvf));
    chk({tag, " R5 window"}, int'(windowTicks),
        expValid ? best - (RL - 1) : (expOvf ? MAXT : 0));
    chk({tag, " R6 rail"}, int'(sagRail), expValid ? bidx : 0);
  endtask

  task automatic clearProfile();
    nom[0] = 4000; nom[1] = 2500; nom[2] = 1200;
    for (int r = 0; r < NR; r++) begin
      lowLvl[r] = thrOf(nom[r]) - 1;
      sagAt[r] = NONE;
      glitchAt[r] = NONE;
    end
    abortAt = NONE;
    gap = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int sets[4];
    sets[0] = 0; sets[1] = 3; sets[2] = 40; sets[3] = NONE;
    clearProfile();
    setNominals();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset valid", int'(windowValid), 0);
    chk("R1 reset overflow", int'(windowOverflow), 0);
    chk("R1 reset window", int'(windowTicks), 0);
    chk("R1 reset rail", int'(sagRail), 0);
    // R1: no arm yet, a full fall and sag must be ignored
    sagAt[0] = 0;
    strobeIdle(1'b1, 2);
    for (int k = 0; k < 40; k++) driveTick(k);
    @(negedge clk);
    chk("R1 unarmed valid", int'(windowValid), 0);

    // R4/R5/R6/R3: sweep of sag starts, ties and strobe gaps
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++) begin
          clearProfile();
          sagAt[0] = sets[a];
          sagAt[1] = sets[b];
          sagAt[2] = (c == 0) ? 7 : NONE;
          gap = ((a + b + c) % 2) + 1;
          runCase("R4 sweep", 1'b1);
        end

    // R3: glitch resets run
    clearProfile(); sagAt[0] = 10; glitchAt[0] = 20; sagAt[1] = 15;
    runCase("R3 glitch", 1'b1);
    clearProfile(); sagAt[0] = 10; glitchAt[0] = 34;
    runCase("R3 glitch last", 1'b1);
    clearProfile(); sagAt[0] = 10; glitchAt[0] = 35;
    runCase("R3 glitch after", 1'b1);

    // R2: level equal to threshold is not a sag
    clearProfile(); lowLvl[0] = thrOf(nom[0]); sagAt[0] = 0; sagAt[1] = 50;
    runCase("R2 at threshold", 1'b1);

    // R7: abort before and on the declaring strobe
    clearProfile(); sagAt[0] = 10; abortAt = 33;
    runCase("R7 abort early", 1'b1);
    clearProfile(); sagAt[0] = 10; abortAt = 34;
    runCase("R7 abort same", 1'b1);

    // R8/R5: saturation boundary
    clearProfile();
    runCase("R8 no sag", 1'b1);
    clearProfile(); sagAt[2] = MAXT - 24;
    runCase("R5 last tick", 1'b1);
    clearProfile(); sagAt[2] = MAXT - 23;
    runCase("R8 one late", 1'b1);

    // R9: arm clears a held result
    clearProfile(); sagAt[1] = 5;
    runCase("R9 pre", 1'b1);
    pulseArm(1'b1);
    chk("R9 cleared valid", int'(windowValid), 0);
    chk("R9 cleared window", int'(windowTicks), 0);
    chk("R9 cleared rail", int'(sagRail), 0);
    // R9: re-arm mid-measurement then measure normally
    clearProfile(); sagAt[0] = 0; setNominals();
    pulseArm(1'b1);
    strobeIdle(1'b1, 2);
    for (int k = 0; k < 10; k++) driveTick(k);
    clearProfile(); sagAt[1] = 12;
    runCase("R9 rearm", 1'b1);

    // R10: armed while power-good low
    clearProfile(); sagAt[0] = 0; setNominals();
    pulseArm(1'b0);
    abortAt = NONE;
    pwrGood = 1'b0;
    for (int k = 0; k < 40; k++) begin
      for (int r = 0; r < NR; r++) railLevel[r*SW +: SW] = SW'(lowLvl[r]);
      sampleStb = 1'b1;
      @(negedge clk);
      sampleStb = 1'b0;
      @(negedge clk);
    end
    chk("R10 no start valid", int'(windowValid), 0);
    chk("R10 no start overflow", int'(windowOverflow), 0);
    clearProfile(); sagAt[0] = 5;
    runCase("R10 later fall", 1'b0);

    // R11: result held across further sags and power-good return
    clearProfile(); sagAt[2] = 8;
    runCase("R11 pre", 1'b1);
    clearProfile(); sagAt[0] = 0; sagAt[1] = 0; abortAt = 3;
    for (int k = 0; k < 30; k++) driveTick(k);
    chk("R11 held valid", int'(windowValid), 1);
    chk("R11 held window", int'(windowTicks), 8);
    chk("R11 held rail", int'(sagRail), 2);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule